// File: doc/BRIEF.md
# Segment Lookaside Buffer with Hint-Driven Bulk Invalidate

The block holds a small, fully associative table of segment translations. Each slot carries a valid flag, an effective segment number, a virtual segment number and a one-bit class. Entries are loaded one per cycle through a write port and can be read back by index. A bulk invalidate request carries a full instruction word. A three-bit hint inside that word selects which valid entries lose their valid flag. Every request also sets a sticky flag that tells the translation caches downstream that they need a local flush.

Two hint sets are supported. When `ext_hints` is high, the extended set applies. Some hints then also sweep slot 0. One hint spares class-0 entries. One hint clears nothing at all. An undefined hint falls back to the default sweep and raises an error pulse. When `ext_hints` is low, every hint behaves like the default sweep, and slot 0 is never touched. The sweep covers all slots in one clock edge. A done pulse follows in the next cycle.

Top module: `slb_bulk_inval`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every valid flag, every stored field, the sticky flush flag and the done and error pulses.
- R2: A write with `wr_en` high and no invalidate in the same cycle stores valid, segment numbers and class at `wr_idx` at that edge. The read port shows the slot chosen by `rd_idx` combinationally.
- R3: Hints 0, 1, 2 and 6 clear the valid flag of every valid slot except slot 0, in either mode.
- R4: With `ext_hints` high, hint 4 clears every valid slot, slot 0 included.
- R5: With `ext_hints` high, hint 3 sweeps from slot 0. It clears only valid slots whose class bit is 1 and keeps slots whose class bit is 0.
- R6: With `ext_hints` high, hint 7 clears no slot.
- R7: With `ext_hints` high, hint 5 sweeps like hint 0, and `hint_err` is high for exactly the one cycle after the request. With `ext_hints` low, `hint_err` stays low.
- R8: With `ext_hints` low, hints 3, 4, 5 and 7 all sweep like hint 0 and spare slot 0.
- R9: An invalidate changes only valid flags. Segment numbers and class bits of every slot stay as they were.
- R10: `inv_done` is high in exactly the cycle after each accepted request and low otherwise.
- R11: Every request, hint 7 included, sets `flush_needed` at its edge. The flag stays set until an edge with `flush_ack` high and no request. A request in the same cycle as an ack leaves the flag set.
- R12: A write that arrives together with an invalidate is held back and lands at the next edge without a request, so it survives the sweep. A newer write in that later cycle is applied after the held one.
- R13: The hint is bits 23 down to 21 of `inv_insn` (bit 21 least significant). All other bits of the word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Load one slot |
| wr_idx | input | IDX_W (5) | Slot to load |
| wr_esid | input | ESID_W (36) | Effective segment number to store |
| wr_vsid | input | VSID_W (50) | Virtual segment number to store |
| wr_cls | input | 1 | Class bit to store |
| wr_valid | input | 1 | Valid flag to store |
| inv_req | input | 1 | Bulk invalidate request |
| inv_insn | input | INSN_W (32) | Instruction word holding the hint in bits 23:21 |
| ext_hints | input | 1 | 1 selects the extended hint set, 0 the legacy set |
| flush_ack | input | 1 | Clears the sticky flush flag |
| rd_idx | input | IDX_W (5) | Slot to read |
| rd_valid | output | 1 | Valid flag of the read slot |
| rd_esid | output | ESID_W (36) | Effective segment number of the read slot |
| rd_vsid | output | VSID_W (50) | Virtual segment number of the read slot |
| rd_cls | output | 1 | Class bit of the read slot |
| inv_done | output | 1 | One-cycle pulse after each request |
| hint_err | output | 1 | One-cycle pulse after a request with an undefined hint |
| flush_needed | output | 1 | Sticky request for a local translation-cache flush |

## Verification
Before each sweep the table is refilled so that class bits alternate between neighbouring slots and slot 5 holds fields but no valid flag. One fill pattern therefore separates the effects of the hints: whether slot 0 is spared, whether class-0 slots survive, whether anything is cleared, and whether an invalid slot's fields stay the same. The same hints are then sent with `ext_hints` low to show that the legacy set folds them all onto the default sweep. The other bits of the instruction word carry patterns of all ones and of mixed ones and zeros, which would expose a hint taken from the wrong position. Writes that collide with a sweep, back-to-back writes to the same slot, and an ack in the same cycle as a request each test one ordering rule.

// File: rtl/slb_pkg.sv
package slb_pkg;

    localparam int HINT_W = 3;

    // Hint codes whose meaning differs under the extended set.
    localparam logic [HINT_W-1:0] HINT_CLASS1_ONLY = 3'd3;
    localparam logic [HINT_W-1:0] HINT_WHOLE       = 3'd4;
    localparam logic [HINT_W-1:0] HINT_UNDEFINED   = 3'd5;
    localparam logic [HINT_W-1:0] HINT_NO_SWEEP    = 3'd7;

    // Sweep controls produced by the hint decoder.
    typedef struct packed {
        logic from_zero;   // sweep includes slot 0
        logic keep_cls0;   // valid class-0 slots survive
        logic skip_all;    // no slot is cleared
        logic bad_hint;    // undefined hint under extended set
    } sweep_ctl_t;

endpackage

// File: rtl/slb_hint_decode.sv
module slb_hint_decode
    import slb_pkg::*;
(
    input  logic [HINT_W-1:0] hint,
    input  logic              ext_hints,
    output sweep_ctl_t        ctl
);

    always_comb begin
        ctl = '0;
        if (ext_hints) begin
            case (hint)
                HINT_NO_SWEEP: begin
                    ctl.skip_all = 1'b1;
                end
                HINT_CLASS1_ONLY: begin
                    ctl.from_zero = 1'b1;
                    ctl.keep_cls0 = 1'b1;
                end
                HINT_WHOLE: begin
                    ctl.from_zero = 1'b1;
                end
                HINT_UNDEFINED: begin
                    ctl.bad_hint = 1'b1;
                end
                default: begin
                    ctl = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/slb_entry_array.sv
module slb_entry_array
    import slb_pkg::*;
#(
    parameter int N_ENT  = 32,
    parameter int ESID_W = 36,
    parameter int VSID_W = 50,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ESID_W-1:0] wr_esid,
    input  logic [VSID_W-1:0] wr_vsid,
    input  logic              wr_cls,
    input  logic              wr_valid,
    input  logic              inv_go,
    input  sweep_ctl_t        ctl,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ESID_W-1:0] rd_esid,
    output logic [VSID_W-1:0] rd_vsid,
    output logic              rd_cls
);

    typedef struct packed {
        logic [N_ENT-1:0]             vld;
        logic [N_ENT-1:0]             cls;
        logic [N_ENT-1:0][ESID_W-1:0] esid;
        logic [N_ENT-1:0][VSID_W-1:0] vsid;
        logic                         pnd;
        logic [IDX_W-1:0]             pidx;
        logic [ESID_W-1:0]            pesid;
        logic [VSID_W-1:0]            pvsid;
        logic                         pcls;
        logic                         pvalid;
    } arr_st_t;

    arr_st_t          s_d, s_q;
    logic [N_ENT-1:0] kill;

    // Per-slot clear decision; slot 0 is gated by the sweep start.
    for (genvar g = 0; g < N_ENT; g++) begin : g_kill
        if (g == 0) begin : g_first
            assign kill[g] = s_q.vld[g] & ~ctl.skip_all & ctl.from_zero
                           & ~(ctl.keep_cls0 & ~s_q.cls[g]);
        end else begin : g_rest
            assign kill[g] = s_q.vld[g] & ~ctl.skip_all
                           & ~(ctl.keep_cls0 & ~s_q.cls[g]);
        end
    end

    always_comb begin
        s_d = s_q;
        if (inv_go) begin
            s_d.vld = s_q.vld & ~kill;
            if (wr_en) begin
                s_d.pnd    = 1'b1;
                s_d.pidx   = wr_idx;
                s_d.pesid  = wr_esid;
                s_d.pvsid  = wr_vsid;
                s_d.pcls   = wr_cls;
                s_d.pvalid = wr_valid;
            end
        end else begin
            if (s_q.pnd) begin
                s_d.vld[s_q.pidx]  = s_q.pvalid;
                s_d.cls[s_q.pidx]  = s_q.pcls;
                s_d.esid[s_q.pidx] = s_q.pesid;
                s_d.vsid[s_q.pidx] = s_q.pvsid;
            end
            s_d.pnd = 1'b0;
            if (wr_en) begin
                s_d.vld[wr_idx]  = wr_valid;
                s_d.cls[wr_idx]  = wr_cls;
                s_d.esid[wr_idx] = wr_esid;
                s_d.vsid[wr_idx] = wr_vsid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid = s_q.vld[rd_idx];
    assign rd_cls   = s_q.cls[rd_idx];
    assign rd_esid  = s_q.esid[rd_idx];
    assign rd_vsid  = s_q.vsid[rd_idx];

    // R6: the no-sweep hint leaves every valid flag as it was
    a_r6_skip_keeps_all: assert property (@(posedge clk) disable iff (rst)
        inv_go && ctl.skip_all |=> s_q.vld == $past(s_q.vld));

    // R3: a sweep not starting at slot 0 leaves slot 0 alone
    a_r3_slot0_spared: assert property (@(posedge clk) disable iff (rst)
        inv_go && !ctl.from_zero |=> s_q.vld[0] == $past(s_q.vld[0]));

    // R4: full sweep without class filter empties the table
    a_r4_whole_sweep: assert property (@(posedge clk) disable iff (rst)
        inv_go && ctl.from_zero && !ctl.keep_cls0 && !ctl.skip_all
        |=> s_q.vld == '0);

    // R5: class-0 slots that were valid are still valid
    a_r5_class0_survive: assert property (@(posedge clk) disable iff (rst)
        inv_go && ctl.keep_cls0
        |=> ((($past(s_q.vld) & ~$past(s_q.cls)) & ~s_q.vld) == '0));

    // R9: a sweep touches no field other than the valid flags
    a_r9_fields_kept: assert property (@(posedge clk) disable iff (rst)
        inv_go |=> (s_q.esid == $past(s_q.esid)) && (s_q.vsid == $past(s_q.vsid))
                   && (s_q.cls == $past(s_q.cls)));

    // R12: a write colliding with a sweep is held for the next cycle
    a_r12_write_held: assert property (@(posedge clk) disable iff (rst)
        inv_go && wr_en |=> s_q.pnd);

endmodule

// File: rtl/slb_flush_ctl.sv
module slb_flush_ctl (
    input  logic clk,
    input  logic rst,
    input  logic inv_go,
    input  logic bad_hint,
    input  logic flush_ack,
    output logic inv_done,
    output logic hint_err,
    output logic flush_needed
);

    typedef struct packed {
        logic flush;
        logic done;
        logic err;
    } fl_st_t;

    fl_st_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.done = inv_go;
        f_d.err  = inv_go & bad_hint;
        if (inv_go) begin
            f_d.flush = 1'b1;
        end else if (flush_ack) begin
            f_d.flush = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign inv_done     = f_q.done;
    assign hint_err     = f_q.err;
    assign flush_needed = f_q.flush;

    // R10: each request is followed by a done pulse
    a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
        inv_go |=> inv_done);

    // R10: no done pulse without a request one cycle before
    a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !inv_go |=> !inv_done);

    // R11: a request always leaves the flush flag set
    a_r11_flush_set: assert property (@(posedge clk) disable iff (rst)
        inv_go |=> flush_needed);

    // R11: without an ack the flag holds
    a_r11_flush_sticky: assert property (@(posedge clk) disable iff (rst)
        flush_needed && !flush_ack |=> flush_needed);

    // R7: an error pulse only accompanies a done pulse
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        hint_err |-> inv_done);

endmodule

// File: rtl/slb_bulk_inval.sv
module slb_bulk_inval
    import slb_pkg::*;
#(
    parameter int N_ENT    = 32,
    parameter int ESID_W   = 36,
    parameter int VSID_W   = 50,
    parameter int INSN_W   = 32,
    parameter int HINT_LSB = 21,
    localparam int IDX_W   = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ESID_W-1:0] wr_esid,
    input  logic [VSID_W-1:0] wr_vsid,
    input  logic              wr_cls,
    input  logic              wr_valid,
    input  logic              inv_req,
    input  logic [INSN_W-1:0] inv_insn,
    input  logic              ext_hints,
    input  logic              flush_ack,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ESID_W-1:0] rd_esid,
    output logic [VSID_W-1:0] rd_vsid,
    output logic              rd_cls,
    output logic              inv_done,
    output logic              hint_err,
    output logic              flush_needed
);

    logic [HINT_W-1:0] hint;
    sweep_ctl_t        ctl;
    logic              unused_insn_rest;

    // R13: hint field position in the instruction word
    assign hint             = inv_insn[HINT_LSB +: HINT_W];
    assign unused_insn_rest = ^inv_insn;

    slb_hint_decode u_dec (
        .hint      (hint),
        .ext_hints (ext_hints),
        .ctl       (ctl)
    );

    slb_entry_array #(
        .N_ENT  (N_ENT),
        .ESID_W (ESID_W),
        .VSID_W (VSID_W)
    ) u_arr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_esid  (wr_esid),
        .wr_vsid  (wr_vsid),
        .wr_cls   (wr_cls),
        .wr_valid (wr_valid),
        .inv_go   (inv_req),
        .ctl      (ctl),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_esid  (rd_esid),
        .rd_vsid  (rd_vsid),
        .rd_cls   (rd_cls)
    );

    slb_flush_ctl u_fl (
        .clk          (clk),
        .rst          (rst),
        .inv_go       (inv_req),
        .bad_hint     (ctl.bad_hint),
        .flush_ack    (flush_ack),
        .inv_done     (inv_done),
        .hint_err     (hint_err),
        .flush_needed (flush_needed)
    );

    // R7: the legacy set never reports an undefined hint
    a_r7_legacy_no_err: assert property (@(posedge clk) disable iff (rst)
        inv_req && !ext_hints |=> !hint_err);

endmodule

// File: tb/slb_bulk_inval_bench.sv
module slb_bulk_inval_bench;

    localparam int PERIOD = 10;
    localparam int N  = 32;
    localparam int EW = 36;
    localparam int VW = 50;
    localparam int IW = 32;
    localparam int XW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [XW-1:0] wr_idx = '0;
    logic [EW-1:0] wr_esid = '0;
    logic [VW-1:0] wr_vsid = '0;
    logic          wr_cls = 1'b0;
    logic          wr_valid = 1'b0;
    logic          inv_req = 1'b0;
    logic [IW-1:0] inv_insn = '0;
    logic          ext_hints = 1'b1;
    logic          flush_ack = 1'b0;
    logic [XW-1:0] rd_idx = '0;
    logic          rd_valid, rd_cls, inv_done, hint_err, flush_needed;
    logic [EW-1:0] rd_esid;
    logic [VW-1:0] rd_vsid;

    slb_bulk_inval u_slb_bulk_inval (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_esid(wr_esid), .wr_vsid(wr_vsid), .wr_cls(wr_cls),
        .wr_valid(wr_valid), .inv_req(inv_req), .inv_insn(inv_insn),
        .ext_hints(ext_hints), .flush_ack(flush_ack), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_esid(rd_esid), .rd_vsid(rd_vsid),
        .rd_cls(rd_cls), .inv_done(inv_done), .hint_err(hint_err),
        .flush_needed(flush_needed)
    );

    always #(PERIOD/2) clk = ~clk;

    // Reference model state
    logic [N-1:0]  m_vld = '0, m_cls = '0;
    logic [EW-1:0] m_esid [N];
    logic [VW-1:0] m_vsid [N];
    logic          m_pnd = 1'b0, m_pcls = 1'b0, m_pvalid = 1'b0;
    int            m_pidx = 0;
    logic [EW-1:0] m_pesid = '0;
    logic [VW-1:0] m_pvsid = '0;
    logic          m_flush = 1'b0, m_done = 1'b0, m_err = 1'b0;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    initial begin
        for (int i = 0; i < N; i++) begin
            m_esid[i] = '0;
            m_vsid[i] = '0;
        end
    end

    function automatic logic [EW-1:0] esid_of(int i, int salt);
        return EW'(64'h0_0A50_0000 + i * 37 + salt * 4099);
    endfunction

    function automatic logic [VW-1:0] vsid_of(int i, int salt);
        return VW'(64'h3_1234_0000_0000 + i * 131 + salt * 65537);
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [2:0] h;
        bit         from0, keep0, none;
        h = inv_insn[23:21];
        if (rst) begin
            m_vld = '0; m_cls = '0; m_pnd = 1'b0; m_flush = 1'b0;
            m_done = 1'b0; m_err = 1'b0; m_pidx = 0; m_pesid = '0;
            m_pvsid = '0; m_pcls = 1'b0; m_pvalid = 1'b0;
            for (int i = 0; i < N; i++) begin
                m_esid[i] = '0;
                m_vsid[i] = '0;
            end
        end else if (inv_req) begin
            from0 = 0; keep0 = 0; none = 0;
            if (ext_hints) begin
                if (h == 3'd7) none = 1;
                if (h == 3'd3) begin from0 = 1; keep0 = 1; end
                if (h == 3'd4) from0 = 1;
            end
            for (int i = 0; i < N; i++) begin
                if (m_vld[i] && !none && (i > 0 || from0) && !(keep0 && !m_cls[i]))
                    m_vld[i] = 1'b0;
            end
            if (wr_en) begin
                m_pnd = 1'b1; m_pidx = int'(wr_idx); m_pesid = wr_esid;
                m_pvsid = wr_vsid; m_pcls = wr_cls; m_pvalid = wr_valid;
            end
            m_flush = 1'b1;
            m_done  = 1'b1;
            m_err   = ext_hints && (h == 3'd5);
        end else begin
            if (m_pnd) begin
                m_vld[m_pidx] = m_pvalid; m_cls[m_pidx] = m_pcls;
                m_esid[m_pidx] = m_pesid; m_vsid[m_pidx] = m_pvsid;
            end
            m_pnd = 1'b0;
            if (wr_en) begin
                m_vld[wr_idx] = wr_valid; m_cls[wr_idx] = wr_cls;
                m_esid[wr_idx] = wr_esid; m_vsid[wr_idx] = wr_vsid;
            end
            m_done = 1'b0;
            m_err  = 1'b0;
            if (flush_ack) m_flush = 1'b0;
        end
    endtask

    task automatic compare();
        int k;
        k = int'(rd_idx);
        chk(inv_done == m_done, "R10", "inv_done", 64'(inv_done), 64'(m_done));
        chk(hint_err == m_err, "R7", "hint_err", 64'(hint_err), 64'(m_err));
        chk(flush_needed == m_flush, "R11", "flush_needed",
            64'(flush_needed), 64'(m_flush));
        chk(rd_valid == m_vld[k], cur_tag, $sformatf("valid[%0d]", k),
            64'(rd_valid), 64'(m_vld[k]));
        chk(rd_cls == m_cls[k], cur_tag, $sformatf("cls[%0d]", k),
            64'(rd_cls), 64'(m_cls[k]));
        chk(rd_esid == m_esid[k], cur_tag, $sformatf("esid[%0d]", k),
            64'(rd_esid), 64'(m_esid[k]));
        chk(rd_vsid == m_vsid[k], cur_tag, $sformatf("vsid[%0d]", k),
            64'(rd_vsid), 64'(m_vsid[k]));
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic do_write(int idx, int salt, logic cls, logic v);
        wr_en = 1'b1; wr_idx = XW'(idx); wr_esid = esid_of(idx, salt);
        wr_vsid = vsid_of(idx, salt); wr_cls = cls; wr_valid = v;
        rd_idx = XW'(idx);
        cyc();
        wr_en = 1'b0;
    endtask

    // Slot 5 holds fields but no valid flag; class alternates
    task automatic fill(int salt);
        for (int i = 0; i < N; i++) do_write(i, salt, i[0], (i != 5));
    endtask

    task automatic scan();
        for (int i = 0; i < N; i++) begin
            rd_idx = XW'(i);
            cyc();
        end
    endtask

    task automatic do_inv(logic [2:0] h, logic ext, logic [IW-1:0] junk);
        inv_req = 1'b1;
        inv_insn = (junk & ~(IW'(7) << 21)) | (IW'(h) << 21);
        ext_hints = ext;
        cyc();
        inv_req = 1'b0;
        inv_insn = ~inv_insn;
        cyc();
    endtask

    initial begin
        // R1: reset state
        cur_tag = "R1";
        repeat (3) cyc();
        rst = 1'b0;
        scan();

        // R2: loading and reading back
        cur_tag = "R2";
        fill(1);
        scan();

        // R3 and R9: default sweep, fields of cleared and invalid slots kept
        cur_tag = "R9";
        do_inv(3'd0, 1'b1, 32'h0000_0000);
        scan();
        cur_tag = "R3";
        for (int h = 1; h <= 2; h++) begin
            fill(h + 10);
            do_inv(3'(h), 1'b1, 32'h5A5A_A5A5);
            scan();
        end

        // R13: hint 6 surrounded by ones elsewhere in the word
        cur_tag = "R13";
        fill(20);
        do_inv(3'd6, 1'b1, 32'hFFFF_FFFF);
        scan();

        // R5: class-1-only sweep
        cur_tag = "R5";
        fill(21);
        do_inv(3'd3, 1'b1, 32'h1234_5678);
        scan();

        // R4: whole sweep
        cur_tag = "R4";
        fill(22);
        do_inv(3'd4, 1'b1, 32'h8000_0001);
        scan();

        // R6: no sweep, flush still requested
        cur_tag = "R6";
        flush_ack = 1'b1; cyc(); flush_ack = 1'b0;
        fill(23);
        do_inv(3'd7, 1'b1, 32'h0F0F_0F0F);
        scan();

        // R7: undefined hint, extended set
        cur_tag = "R7";
        fill(24);
        do_inv(3'd5, 1'b1, 32'hFFFF_FFFF);
        scan();

        // R8: legacy set folds every hint onto the default sweep
        cur_tag = "R8";
        fill(30); do_inv(3'd3, 1'b0, 32'h0); scan();
        fill(31); do_inv(3'd4, 1'b0, 32'h0); scan();
        fill(32); do_inv(3'd5, 1'b0, 32'h0); scan();
        fill(33); do_inv(3'd7, 1'b0, 32'h0); scan();
        ext_hints = 1'b1;

        // R11: sticky flag, ack alone clears, ack with request does not
        cur_tag = "R11";
        repeat (4) cyc();
        flush_ack = 1'b1; cyc(); flush_ack = 1'b0;
        cyc();
        do_inv(3'd7, 1'b1, 32'h0);
        flush_ack = 1'b1; inv_req = 1'b1; inv_insn = 32'h00E0_0000;
        cyc();
        inv_req = 1'b0; flush_ack = 1'b0;
        repeat (2) cyc();

        // R12: write colliding with a sweep, then a newer write to the same slot
        cur_tag = "R12";
        fill(40);
        inv_req = 1'b1; inv_insn = 32'h0; rd_idx = XW'(7);
        wr_en = 1'b1; wr_idx = XW'(7); wr_esid = esid_of(7, 99);
        wr_vsid = vsid_of(7, 99); wr_cls = 1'b0; wr_valid = 1'b1;
        cyc();
        inv_req = 1'b0; wr_idx = XW'(7); wr_esid = esid_of(7, 77);
        wr_vsid = vsid_of(7, 77); wr_cls = 1'b1;
        cyc();
        inv_req = 1'b1; wr_idx = XW'(9); wr_esid = esid_of(9, 55);
        cyc();
        inv_req = 1'b0; wr_en = 1'b0;
        cyc();
        scan();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule